// File: doc/BRIEF.md
# Paging Codeword Call Matcher

This block sits behind the error-correction stage of a paging receiver. It takes one corrected 32-bit codeword per strobe, together with the codeword's slot number (0 to 15) inside the current batch. Each word is sorted into one of four kinds: synchronisation word, idle word, address word or message word. Address words are compared against a 21-bit user address. The upper bits of that address must equal the address field of the word. The low three bits name the frame, and the frame is derived from the slot as slot divided by two. The address field itself does not carry the frame.

A match raises a one-cycle indication together with the call type, which is read from the two function bits. For numeric and alphanumeric calls, the block then passes on the 20-bit payload of every following message word, whatever slot it arrives in. Synchronisation words that come in between are skipped. The call closes with an end pulse when an idle word or any address word arrives. The block does not do bit alignment, error correction or character unpacking.

Top module: `pager_cw_matcher`

## Requirements
- R1: Word kinds are decided as follows. A word equal to 32'h7CD215D8 is a sync word and a word equal to 32'h7A89C197 is an idle word, even though bit 31 of both is 0. Any other word is an address word when bit 31 is 0 and a message word when bit 31 is 1. Sync and idle words never produce a match.
- R2: An address word matches only when both of these hold: its bits 30:13 equal user_addr[20:3], and cw_slot[3:1] equals user_addr[2:0]. On a match, match_valid is high for exactly the one cycle after the strobe.
- R3: With match_valid, call_type carries bits 12:11 of the matched word. The codes are 00 numeric, 11 alphanumeric, and 01 or 10 alert-only. Every code is accepted without rejection.
- R4: An alert-only match opens no call, so message words that follow it produce no msg_valid.
- R5: After a numeric or alphanumeric match, each message word produces msg_valid in the cycle after its strobe, with msg_data equal to bits 30:11 of that word, in any slot.
- R6: A sync word that arrives during an open call produces no output and leaves the call open.
- R7: An idle word during an open call gives a one-cycle msg_end pulse and closes the call.
- R8: Any address word during an open call gives msg_end. If that word also matches, match_valid is raised in the same cycle, and a numeric or alphanumeric type opens a new call.
- R9: With no call open, message, idle and sync words, and non-matching address words, produce no output.
- R10: While rst_n is low at a clock edge, match_valid, msg_valid and msg_end are 0 and no call is open.
- R11: A cycle whose edge sees cw_valid low produces no pulse on match_valid, msg_valid or msg_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_addr | input | 21 | Programmed user address; low 3 bits are the frame |
| cw_valid | input | 1 | Strobe: cw_data and cw_slot hold a codeword |
| cw_data | input | 32 | Corrected codeword, bit 31 sent first |
| cw_slot | input | 4 | Codeword slot in the batch, 0 to 15 |
| match_valid | output | 1 | One-cycle pulse: address matched |
| call_type | output | 2 | Function bits of the last matched address |
| msg_valid | output | 1 | One-cycle pulse: msg_data holds a payload |
| msg_data | output | 20 | Payload of the forwarded message word |
| msg_end | output | 1 | One-cycle pulse: open call closed |

## Verification
The hardest cases to reach from the ports are those where a reserved word carries an address field that would otherwise match. The idle and sync constants both have bit 31 at 0. The stimulus therefore programs user_addr with the idle word's own field and frame, and with the sync word's field, then presents those constants in a matching slot and expects silence. It follows with a genuine address word that has the same field, to show that the match logic is live. The other hard case is the change-over from one call to the next in a single word: an open call is closed by a matching address word, and the bench expects msg_end and match_valid together, followed by payload forwarding under the new call type.

// File: rtl/pager_pkg.sv
// Shared constants and types for the paging codeword matcher.
// Assumes a 32-bit codeword with bit 31 transmitted first.
package pager_pkg;
    localparam int CW_W = 32;
    localparam logic [CW_W-1:0] SYNC_CW = 32'h7CD215D8;
    localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89C197;

    typedef enum logic [1:0] {
        WK_SYNC,
        WK_IDLE,
        WK_ADDR,
        WK_MSG
    } word_kind_e;

    typedef enum logic [1:0] {
        CT_NUMERIC = 2'b00,
        CT_ALERT_A = 2'b01,
        CT_ALERT_B = 2'b10,
        CT_ALPHA   = 2'b11
    } call_type_e;

    // True for the call types that carry message words after the address.
    function automatic logic carries_msg(input logic [1:0] fn);
        return (fn == CT_NUMERIC) || (fn == CT_ALPHA);
    endfunction
endpackage

// File: rtl/pager_classify.sv
// Sorts a codeword into sync, idle, address or message.
// Assumes: the reserved words take priority over the flag bit.
module pager_classify
    import pager_pkg::*;
(
    input  logic [CW_W-1:0] cw_data,
    output word_kind_e      kind
);
    // Purpose: reserved constant compare first, then the leading flag bit.
    always_comb begin
        if (cw_data == SYNC_CW)
            kind = WK_SYNC;
        else if (cw_data == IDLE_CW)
            kind = WK_IDLE;
        else if (cw_data[CW_W-1])
            kind = WK_MSG;
        else
            kind = WK_ADDR;
    end
endmodule

// File: rtl/pager_addr_cmp.sv
// Compares an address field and the slot-derived frame against the user address.
// Assumes: the frame index is the slot with its lowest bit dropped.
module pager_addr_cmp #(
    parameter int ADDR_W  = 21,
    parameter int FRAME_W = 3,
    localparam int FIELD_W = ADDR_W - FRAME_W,
    localparam int SLOT_W  = FRAME_W + 1
) (
    input  logic [ADDR_W-1:0]  user_addr,
    input  logic [FIELD_W-1:0] field,
    input  logic [SLOT_W-1:1]  frame,
    output logic               hit
);
    // Purpose: both the carried upper bits and the implied frame must agree.
    always_comb begin
        hit = (field == user_addr[ADDR_W-1:FRAME_W]) &&
              (frame == user_addr[FRAME_W-1:0]);
    end
endmodule

// File: rtl/pager_call_fsm.sv
// Tracks whether a call is open and drives the registered result pulses.
// Assumes: one decision per strobe; outputs appear one cycle after it.
module pager_call_fsm
    import pager_pkg::*;
#(
    parameter int MSG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  word_kind_e       kind,
    input  logic             hit,
    input  logic [1:0]       fn,
    input  logic [MSG_W-1:0] payload,
    output logic             match_valid,
    output logic [1:0]       call_type,
    output logic             msg_valid,
    output logic [MSG_W-1:0] msg_data,
    output logic             msg_end
);
    logic in_call;

    // Purpose: update call state and the one-cycle pulses on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_call     <= 1'b0;
            match_valid <= 1'b0;
            call_type   <= 2'b00;
            msg_valid   <= 1'b0;
            msg_data    <= '0;
            msg_end     <= 1'b0;
        end else begin
            match_valid <= 1'b0;
            msg_valid   <= 1'b0;
            msg_end     <= 1'b0;
            if (valid) begin
                case (kind)
                    WK_SYNC: ;
                    WK_IDLE: begin
                        if (in_call) msg_end <= 1'b1;
                        in_call <= 1'b0;
                    end
                    WK_ADDR: begin
                        if (in_call) msg_end <= 1'b1;
                        in_call <= hit && carries_msg(fn);
                        if (hit) begin
                            match_valid <= 1'b1;
                            call_type   <= fn;
                        end
                    end
                    WK_MSG: begin
                        if (in_call) begin
                            msg_valid <= 1'b1;
                            msg_data  <= payload;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pager_cw_matcher.sv
// Top: classifies codewords, matches the user address in its frame and
// forwards message payloads of matched numeric/alphanumeric calls.
// Assumes: codewords already corrected; slot numbers 0..2**SLOT_W-1.
module pager_cw_matcher
    import pager_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int FRAME_W = 3,
    parameter int MSG_W   = 20,
    localparam int FIELD_W   = ADDR_W - FRAME_W,
    localparam int SLOT_W    = FRAME_W + 1,
    localparam int FLAG_BIT  = CW_W - 1,
    localparam int FIELD_LSB = FLAG_BIT - FIELD_W,
    localparam int FN_LSB    = FIELD_LSB - 2,
    localparam int MSG_LSB   = FLAG_BIT - MSG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] user_addr,
    input  logic              cw_valid,
    input  logic [CW_W-1:0]   cw_data,
    input  logic [SLOT_W-1:0] cw_slot,
    output logic              match_valid,
    output logic [1:0]        call_type,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_data,
    output logic              msg_end
);
    word_kind_e kind;
    logic       hit;

    pager_classify u_classify (
        .cw_data (cw_data),
        .kind    (kind)
    );

    pager_addr_cmp #(
        .ADDR_W  (ADDR_W),
        .FRAME_W (FRAME_W)
    ) u_addr_cmp (
        .user_addr (user_addr),
        .field     (cw_data[FLAG_BIT-1:FIELD_LSB]),
        .frame     (cw_slot[SLOT_W-1:1]),
        .hit       (hit)
    );

    pager_call_fsm #(
        .MSG_W (MSG_W)
    ) u_call_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (cw_valid),
        .kind        (kind),
        .hit         (hit),
        .fn          (cw_data[FIELD_LSB-1:FN_LSB]),
        .payload     (cw_data[FLAG_BIT-1:MSG_LSB]),
        .match_valid (match_valid),
        .call_type   (call_type),
        .msg_valid   (msg_valid),
        .msg_data    (msg_data),
        .msg_end     (msg_end)
    );
endmodule

// File: rtl/pager_cw_matcher_chk.sv
// Port-level assertions for pager_cw_matcher, bound to every instance.
module pager_cw_matcher_chk
    import pager_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int FRAME_W = 3,
    parameter int MSG_W   = 20,
    localparam int FIELD_W   = ADDR_W - FRAME_W,
    localparam int FLAG_BIT  = CW_W - 1,
    localparam int FIELD_LSB = FLAG_BIT - FIELD_W,
    localparam int FN_LSB    = FIELD_LSB - 2,
    localparam int MSG_LSB   = FLAG_BIT - MSG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] user_addr,
    input logic              cw_valid,
    input logic [CW_W-1:0]   cw_data,
    input logic [FRAME_W-1:0] cw_frame,
    input logic              match_valid,
    input logic [1:0]        call_type,
    input logic              msg_valid,
    input logic [MSG_W-1:0]  msg_data,
    input logic              msg_end
);
    assert_match_needs_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> ($past(cw_valid) && !$past(cw_data[FLAG_BIT]) &&
                         $past(cw_data[FLAG_BIT-1:FIELD_LSB]) == $past(user_addr[ADDR_W-1:FRAME_W]) &&
                         $past(cw_frame) == $past(user_addr[FRAME_W-1:0])));

    assert_no_reserved_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> ($past(cw_data) != SYNC_CW && $past(cw_data) != IDLE_CW));

    assert_type_from_fn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> call_type == $past(cw_data[FIELD_LSB-1:FN_LSB]));

    assert_alert_opens_nothing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && (call_type == CT_ALERT_A || call_type == CT_ALERT_B)) |=> !msg_valid);

    assert_payload_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(cw_valid) && $past(cw_data[FLAG_BIT]) &&
                       msg_data == $past(cw_data[FLAG_BIT-1:MSG_LSB])));

    assert_end_cause_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end |-> ($past(cw_valid) && ($past(cw_data) == IDLE_CW ||
                     (!$past(cw_data[FLAG_BIT]) && $past(cw_data) != SYNC_CW))));

    assert_quiet_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cw_valid) |-> !(match_valid || msg_valid || msg_end));
endmodule

bind pager_cw_matcher pager_cw_matcher_chk #(
    .ADDR_W  (ADDR_W),
    .FRAME_W (FRAME_W),
    .MSG_W   (MSG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .user_addr   (user_addr),
    .cw_valid    (cw_valid),
    .cw_data     (cw_data),
    .cw_frame    (cw_slot[FRAME_W:1]),
    .match_valid (match_valid),
    .call_type   (call_type),
    .msg_valid   (msg_valid),
    .msg_data    (msg_data),
    .msg_end     (msg_end)
);

// File: tb/pager_cw_matcher_bench.sv
// Scoreboard bench: send() pushes the expected result of each strobe,
// the monitor pops and compares one time unit after the capturing edge.
module pager_cw_matcher_bench;
    localparam logic [31:0] SYNC_W = 32'h7CD215D8;
    localparam logic [31:0] IDLE_W = 32'h7A89C197;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] user_addr = '0;
    logic        cw_valid = 1'b0;
    logic [31:0] cw_data = '0;
    logic [3:0]  cw_slot = '0;
    logic        match_valid, msg_valid, msg_end;
    logic [1:0]  call_type;
    logic [19:0] msg_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic        m;
        logic [1:0]  t;
        logic        v;
        logic [19:0] d;
        logic        e;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    pager_cw_matcher u_pager_cw_matcher (
        .clk (clk), .rst_n (rst_n), .user_addr (user_addr),
        .cw_valid (cw_valid), .cw_data (cw_data), .cw_slot (cw_slot),
        .match_valid (match_valid), .call_type (call_type),
        .msg_valid (msg_valid), .msg_data (msg_data), .msg_end (msg_end)
    );

    function automatic logic [31:0] addr_cw(input logic [20:0] a, input logic [1:0] fn);
        return {1'b0, a[20:3], fn, 10'h155, 1'b1};
    endfunction

    function automatic logic [31:0] msg_cw(input logic [19:0] d);
        return {1'b1, d, 10'h2A6, 1'b0};
    endfunction

    task automatic check(input string req, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] w, input logic [3:0] s, input logic m,
                        input logic [1:0] t, input logic v, input logic e, input string req);
        exp_t x;
        @(negedge clk);
        cw_data  = w;
        cw_slot  = s;
        cw_valid = 1'b1;
        x.m = m; x.t = t; x.v = v; x.d = w[30:11]; x.e = e; x.req = req;
        sb.push_back(x);
        @(negedge clk);
        cw_valid = 1'b0;
    endtask

    // Monitor: compare each strobe's result; check silence on strobe-free edges.
    always @(posedge clk) begin
        if (cw_valid) begin
            #1;
            if (sb.size() == 0) begin
                check("R11", 1'b0, "unexpected strobe", 0, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(x.req, match_valid == x.m, "match_valid", 32'(match_valid), 32'(x.m));
                if (x.m) check(x.req, call_type == x.t, "call_type", 32'(call_type), 32'(x.t));
                check(x.req, msg_valid == x.v, "msg_valid", 32'(msg_valid), 32'(x.v));
                if (x.v) check(x.req, msg_data == x.d, "msg_data", 32'(msg_data), 32'(x.d));
                check(x.req, msg_end == x.e, "msg_end", 32'(msg_end), 32'(x.e));
            end
        end else if (rst_n) begin
            #1;
            check("R11", !(match_valid || msg_valid || msg_end), "idle pulses",
                  {29'd0, match_valid, msg_valid, msg_end}, 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [20:0] a;
        logic [3:0]  f2;
        a  = 21'h1A2B3;
        f2 = {a[2:0], 1'b0};
        user_addr = a;
        repeat (3) @(negedge clk);
        // R10: reset state with strobes held off
        check("R10", !(match_valid || msg_valid || msg_end), "reset pulses",
              {29'd0, match_valid, msg_valid, msg_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: wrong frame, then wrong upper bits
        send(addr_cw(a, 2'b00), f2 + 4'd2, 0, 0, 0, 0, "R2");
        send(addr_cw(a ^ 21'h000008, 2'b00), f2, 0, 0, 0, 0, "R2");
        // R3/R4: alert-only types open no call
        send(addr_cw(a, 2'b01), f2, 1, 2'b01, 0, 0, "R3");
        send(msg_cw(20'h12345), 4'd5, 0, 0, 0, 0, "R4");
        send(addr_cw(a, 2'b10), f2 + 4'd1, 1, 2'b10, 0, 0, "R3");
        send(msg_cw(20'h54321), 4'd9, 0, 0, 0, 0, "R4");
        // R5/R6/R7: numeric call with a sync in the middle, closed by idle
        send(addr_cw(a, 2'b00), f2 + 4'd1, 1, 2'b00, 0, 0, "R3");
        send(msg_cw(20'hABCDE), 4'd9, 0, 0, 1, 0, "R5");
        send(SYNC_W, 4'd0, 0, 0, 0, 0, "R6");
        send(msg_cw(20'h00001), 4'd0, 0, 0, 1, 0, "R6");
        send(msg_cw(20'hFFFFF), 4'd15, 0, 0, 1, 0, "R5");
        send(IDLE_W, 4'd1, 0, 0, 0, 1, "R7");
        send(msg_cw(20'h0F0F0), 4'd2, 0, 0, 0, 0, "R9");
        // R8: alphanumeric call closed by a non-matching address
        send(addr_cw(a, 2'b11), f2, 1, 2'b11, 0, 0, "R3");
        send(msg_cw(20'h7A5A5), 4'd3, 0, 0, 1, 0, "R5");
        send(addr_cw(21'h000010, 2'b00), 4'd0, 0, 0, 0, 1, "R8");
        send(msg_cw(20'h11111), 4'd4, 0, 0, 0, 0, "R8");
        // R8: call handed straight to a new matching call
        send(addr_cw(a, 2'b11), f2, 1, 2'b11, 0, 0, "R3");
        send(msg_cw(20'h22222), 4'd12, 0, 0, 1, 0, "R5");
        send(addr_cw(a, 2'b00), f2 + 4'd1, 1, 2'b00, 0, 1, "R8");
        send(msg_cw(20'h33333), 4'd13, 0, 0, 1, 0, "R8");
        send(addr_cw(a, 2'b01), f2, 1, 2'b01, 0, 1, "R8");
        send(msg_cw(20'h44444), 4'd13, 0, 0, 0, 0, "R8");
        // R9: reserved words outside a call stay silent
        send(IDLE_W, 4'd6, 0, 0, 0, 0, "R9");
        send(SYNC_W, 4'd6, 0, 0, 0, 0, "R9");

        // R1: user address equal to the idle word's own field and frame
        @(negedge clk);
        user_addr = {IDLE_W[30:13], 3'd2};
        send(IDLE_W, 4'd4, 0, 0, 0, 0, "R1");
        send({1'b0, IDLE_W[30:13], 2'b11, 11'h000}, 4'd4, 1, 2'b11, 0, 0, "R1");
        send(msg_cw(20'hCAFE1), 4'd11, 0, 0, 1, 0, "R1");
        send(IDLE_W, 4'd4, 0, 0, 0, 1, "R1");
        @(negedge clk);
        user_addr = {SYNC_W[30:13], 3'd7};
        send(SYNC_W, 4'd14, 0, 0, 0, 0, "R1");
        send({1'b0, SYNC_W[30:13], 2'b01, 11'h001}, 4'd15, 1, 2'b01, 0, 0, "R1");

        // R2: frame boundaries 7 and 0
        @(negedge clk);
        user_addr = {18'h3FFFF, 3'd7};
        send(addr_cw(user_addr, 2'b00), 4'd15, 1, 2'b00, 0, 0, "R2");
        send(msg_cw(20'h80000), 4'd0, 0, 0, 1, 0, "R5");
        send(addr_cw(user_addr, 2'b00), 4'd13, 0, 0, 0, 1, "R2");
        @(negedge clk);
        user_addr = 21'd0;
        send(addr_cw(21'd0, 2'b10), 4'd1, 1, 2'b10, 0, 0, "R2");
        send(addr_cw(21'd0, 2'b10), 4'd2, 0, 0, 0, 0, "R2");

        // R10: reset closes an open call
        send(addr_cw(21'd0, 2'b11), 4'd0, 1, 2'b11, 0, 0, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send(msg_cw(20'h99999), 4'd7, 0, 0, 0, 0, "R10");
        send(IDLE_W, 4'd7, 0, 0, 0, 0, "R10");

        repeat (4) @(negedge clk);
        check("R11", sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule